// File: doc/BRIEF.md
# Escalating Virtual Channel Selector

This block chooses the downstream virtual channel for a packet leaving one router output, in a network where each virtual channel's buffers can be powered off on their own. A packet that enters the network at this router always asks for the lowest channel. A packet that arrives on channel k asks for channel k. If the channel it asks for is busy at the next hop, the selector moves to the next higher free channel. It never picks a channel below the one the packet arrived on. If every candidate channel is busy, the request stalls for that cycle. The scheme keeps traffic on channel 0 under light load, so the higher channels stay empty and can sleep. Under heavy load, conflicts push packets onto every channel.

The block also drives one sleep output per channel. A channel is put to sleep when it holds no flits and the selector is not granting it in the current cycle. A parameter chooses whether channel 0 is always kept powered or follows the same rule as the others. The power switches, the crossbar and switch allocation are outside this block.

Top module: `vc_escalate_sel`

## Requirements
- R1: When a request is flagged as a fresh injection, the search starts at channel 0 and the incoming channel number is ignored.
- R2: For a forwarded request, the search starts at the incoming channel. The grant is the lowest-numbered channel, at or above that start, whose downstream busy flag is low.
- R3: A forwarded request is never granted a channel numbered below its incoming channel.
- R4: If every channel from the start channel upward is busy, no grant is issued in that cycle. The request stalls.
- R5: A grant is registered. `grant_valid` and `grant_vc` show the decision one clock after the request cycle, and `grant_valid` is low one clock after a cycle with no request.
- R6: For every channel that sleep gating covers, `vc_sleep[i]` is registered. One clock after a cycle in which channel i holds no flits and is not being selected, it is 1. Otherwise it is 0.
- R7: With `ALWAYS_ON_VC0` set (the default), `vc_sleep[0]` stays 0 at all times. Channels 1 and above follow R6.
- R8: A forwarded request whose incoming channel number is NUM_VC or more is not granted.
- R9: During reset, `grant_valid` is 0, `grant_vc` is 0, and every sleep output covered by R6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A packet head requests a channel this cycle |
| req_inject | input | 1 | 1: packet is newly injected here (start at channel 0) |
| req_vc | input | VC_W | Channel the packet arrived on |
| dn_busy | input | NUM_VC | Per-channel busy flag of the downstream router |
| vc_occupied | input | NUM_VC | Per-channel flag: channel currently holds flits |
| grant_valid | output | 1 | Registered: a channel was chosen |
| grant_vc | output | VC_W | Registered: the chosen channel |
| vc_sleep | output | NUM_VC | Registered per-channel sleep request |

## Verification
The hardest case to reach is a climb past more than one channel that still respects the arrival floor. This needs a forwarded packet whose own channel is busy, a lower channel that is free (and must be skipped), and a higher channel that is free. The directed tasks set the busy vector and the incoming channel together to build that case, then remove the last free channel to force a stall. Sleep behaviour is checked in the same cycles as the grants. This confirms that a channel being granted wakes in the same clock as the grant appears, while untouched channels stay asleep.

// File: rtl/vcsel_pkg.sv
package vcsel_pkg;
   // Width of a channel index for n channels (at least one bit)
   function automatic int vcw(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/vcsel_start.sv
// Computes the channel at which the upward search begins.
module vcsel_start #(
   parameter int NUM_VC = 3,
   parameter int VC_W   = 2
) (
   input  logic            req_valid,
   input  logic            req_inject,
   input  logic [VC_W-1:0] req_vc,
   output logic [VC_W-1:0] start_vc,
   output logic            start_ok
);
   logic in_range;

   always_comb begin
      in_range = (int'(req_vc) < NUM_VC);
      if (req_inject) begin
         start_vc = '0;
         start_ok = req_valid;
      end else begin
         start_vc = req_vc;
         start_ok = req_valid && in_range;
      end
   end

   // R1: a fresh injection always searches from channel 0
   always_comb begin
      if (req_valid && req_inject) begin
         a_inject_start_r1 : assert (start_vc == '0 && start_ok)
            else $error("inject did not start at channel 0");
      end
   end
endmodule

// File: rtl/vcsel_scan.sv
// Finds the lowest free channel at or above the start channel.
module vcsel_scan #(
   parameter int NUM_VC = 3,
   parameter int VC_W   = 2
) (
   input  logic              start_ok,
   input  logic [VC_W-1:0]   start_vc,
   input  logic [NUM_VC-1:0] busy,
   output logic              sel_valid,
   output logic [VC_W-1:0]   sel_vc
);
   logic [NUM_VC-1:0] cand;

   generate
      for (genvar g = 0; g < NUM_VC; g++) begin : g_cand
         assign cand[g] = start_ok && (g >= int'(start_vc)) && !busy[g];
      end
   endgenerate

   always_comb begin
      sel_valid = 1'b0;
      sel_vc    = '0;
      for (int i = NUM_VC - 1; i >= 0; i--) begin
         if (cand[i]) begin
            sel_valid = 1'b1;
            sel_vc    = VC_W'(i);
         end
      end
   end

   // R2: a selection is always a channel reported free
   always_comb begin
      if (sel_valid) begin
         a_sel_free_r2 : assert (!busy[sel_vc])
            else $error("selected a busy channel");
      end
   end
endmodule

// File: rtl/vcsel_sleep.sv
// Per-channel registered sleep requests.
module vcsel_sleep #(
   parameter int NUM_VC        = 3,
   parameter int VC_W          = 2,
   parameter bit ALWAYS_ON_VC0 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_VC-1:0] occupied,
   input  logic              sel_valid,
   input  logic [VC_W-1:0]   sel_vc,
   output logic [NUM_VC-1:0] vc_sleep
);
   generate
      for (genvar g = 0; g < NUM_VC; g++) begin : g_ch
         if (g == 0 && ALWAYS_ON_VC0) begin : g_on
            assign vc_sleep[g] = 1'b0;
         end else begin : g_gated
            logic wanted;
            logic slp_q;
            assign wanted = sel_valid && (int'(sel_vc) == g);
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) slp_q <= 1'b1;
               else        slp_q <= !occupied[g] && !wanted;
            end
            assign vc_sleep[g] = slp_q;

            // R6: a channel holding flits is awake on the next clock
            p_occupied_awake_r6 : assert property (
               @(posedge clk) disable iff (!rst_n)
               occupied[g] |=> !vc_sleep[g]);
         end
      end
   endgenerate
endmodule

// File: rtl/vc_escalate_sel.sv
module vc_escalate_sel #(
   parameter int NUM_VC        = 3,
   parameter bit ALWAYS_ON_VC0 = 1'b1,
   localparam int VC_W         = vcsel_pkg::vcw(NUM_VC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_inject,
   input  logic [VC_W-1:0]   req_vc,
   input  logic [NUM_VC-1:0] dn_busy,
   input  logic [NUM_VC-1:0] vc_occupied,
   output logic              grant_valid,
   output logic [VC_W-1:0]   grant_vc,
   output logic [NUM_VC-1:0] vc_sleep
);
   generate
      if (NUM_VC < 2) begin : g_bad_num
         $error("vc_escalate_sel: NUM_VC must be at least 2");
      end
      if (NUM_VC > 64) begin : g_bad_big
         $error("vc_escalate_sel: NUM_VC limited to 64");
      end
   endgenerate

   logic [VC_W-1:0] start_vc;
   logic            start_ok;
   logic            sel_valid;
   logic [VC_W-1:0] sel_vc;

   vcsel_start #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_start (
      .req_valid (req_valid),
      .req_inject(req_inject),
      .req_vc    (req_vc),
      .start_vc  (start_vc),
      .start_ok  (start_ok)
   );

   vcsel_scan #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_scan (
      .start_ok (start_ok),
      .start_vc (start_vc),
      .busy     (dn_busy),
      .sel_valid(sel_valid),
      .sel_vc   (sel_vc)
   );

   vcsel_sleep #(.NUM_VC(NUM_VC), .VC_W(VC_W), .ALWAYS_ON_VC0(ALWAYS_ON_VC0)) u_sleep (
      .clk      (clk),
      .rst_n    (rst_n),
      .occupied (vc_occupied),
      .sel_valid(sel_valid),
      .sel_vc   (sel_vc),
      .vc_sleep (vc_sleep)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_vc    <= '0;
      end else begin
         grant_valid <= sel_valid;
         grant_vc    <= sel_valid ? sel_vc : '0;
      end
   end

   // R1: injected packet with channel 0 free lands on channel 0
   p_inject_vc0_r1 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (req_valid && req_inject && !dn_busy[0]) |=> (grant_valid && grant_vc == '0));

   // R3: no descent below the arrival channel
   p_no_descent_r3 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (req_valid && !req_inject) |=> (!grant_valid || grant_vc >= $past(req_vc)));

   // R4: all channels busy means stall
   p_full_stall_r4 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (req_valid && (&dn_busy)) |=> !grant_valid);

   // R5: no request, no grant on the next clock
   p_idle_no_grant_r5 : assert property (
      @(posedge clk) disable iff (!rst_n)
      !req_valid |=> !grant_valid);

   // R6: a granted channel is never asleep
   p_grant_awake_r6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      grant_valid |-> !vc_sleep[grant_vc]);

   // R8: out-of-range arrival channel is never granted
   p_range_r8 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (req_valid && !req_inject && int'(req_vc) >= NUM_VC) |=> !grant_valid);
endmodule

// File: tb/vc_escalate_sel_test.sv
module vc_escalate_sel_test;
   localparam int NUM_VC = 3;
   localparam int VC_W   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_inject = 1'b0;
   logic [VC_W-1:0]   req_vc = '0;
   logic [NUM_VC-1:0] dn_busy = '0;
   logic [NUM_VC-1:0] vc_occupied = '0;
   logic              grant_valid;
   logic [VC_W-1:0]   grant_vc;
   logic [NUM_VC-1:0] vc_sleep;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   vc_escalate_sel #(.NUM_VC(NUM_VC)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inject(req_inject),
      .req_vc(req_vc), .dn_busy(dn_busy), .vc_occupied(vc_occupied),
      .grant_valid(grant_valid), .grant_vc(grant_vc), .vc_sleep(vc_sleep)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive one cycle at negedge, sample at the following negedge
   task automatic step(input bit v, input bit inj, input int vc,
                       input logic [NUM_VC-1:0] busy, input logic [NUM_VC-1:0] occ);
      req_valid   = v;
      req_inject  = inj;
      req_vc      = VC_W'(vc);
      dn_busy     = busy;
      vc_occupied = occ;
      @(posedge clk);
      @(negedge clk);
   endtask

   // expected sleep: channel 0 always awake, others asleep if empty and not chosen
   function automatic logic [NUM_VC-1:0] exp_sleep(input logic [NUM_VC-1:0] occ,
                                                   input bit gv, input int gvc);
      logic [NUM_VC-1:0] s;
      for (int i = 0; i < NUM_VC; i++) s[i] = !occ[i] && !(gv && gvc == i);
      s[0] = 1'b0;
      return s;
   endfunction

   task automatic expect_grant(input string req, input bit gv, input int gvc);
      check(grant_valid == gv, req, int'(grant_valid), int'(gv));
      if (gv) check(int'(grant_vc) == gvc, req, int'(grant_vc), gvc);
   endtask

   task automatic t_reset;
      check(grant_valid == 1'b0, "R9", int'(grant_valid), 0);
      check(grant_vc == '0, "R9", int'(grant_vc), 0);
      check(vc_sleep == 3'b110, "R9", int'(vc_sleep), 6);
   endtask

   task automatic t_inject;
      step(1, 1, 2, 3'b000, 3'b000);
      expect_grant("R1", 1, 0);
      step(1, 1, 2, 3'b001, 3'b000);
      expect_grant("R1", 1, 1);
      check(vc_sleep == exp_sleep(3'b000, 1, 1), "R6", int'(vc_sleep), 4);
      step(1, 1, 0, 3'b011, 3'b000);
      expect_grant("R2", 1, 2);
      step(1, 1, 0, 3'b111, 3'b000);
      expect_grant("R4", 0, 0);
   endtask

   task automatic t_forward;
      step(1, 0, 1, 3'b000, 3'b000);
      expect_grant("R3", 1, 1);
      step(1, 0, 1, 3'b010, 3'b000);
      expect_grant("R2", 1, 2);
      step(1, 0, 0, 3'b001, 3'b000);
      expect_grant("R2", 1, 1);
      step(1, 0, 2, 3'b100, 3'b000);
      expect_grant("R3", 0, 0);
      step(1, 0, 1, 3'b110, 3'b000);
      expect_grant("R4", 0, 0);
      check(vc_sleep == 3'b110, "R6", int'(vc_sleep), 6);
   endtask

   task automatic t_range;
      step(1, 0, 3, 3'b000, 3'b000);
      expect_grant("R8", 0, 0);
      step(1, 1, 3, 3'b000, 3'b000);
      expect_grant("R1", 1, 0);
   endtask

   task automatic t_idle;
      step(1, 0, 2, 3'b000, 3'b000);
      expect_grant("R5", 1, 2);
      step(0, 0, 2, 3'b000, 3'b000);
      expect_grant("R5", 0, 0);
   endtask

   task automatic t_sleep;
      step(0, 0, 0, 3'b100, 3'b100);
      check(vc_sleep == exp_sleep(3'b100, 0, 0), "R6", int'(vc_sleep), 2);
      step(0, 0, 0, 3'b000, 3'b011);
      check(vc_sleep == exp_sleep(3'b011, 0, 0), "R7", int'(vc_sleep), 4);
      step(1, 0, 2, 3'b000, 3'b010);
      check(vc_sleep == 3'b000, "R6", int'(vc_sleep), 0);
      step(0, 0, 0, 3'b000, 3'b000);
      check(vc_sleep == 3'b110, "R6", int'(vc_sleep), 6);
      check(vc_sleep[0] == 1'b0, "R7", int'(vc_sleep[0]), 0);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_inject();
      t_forward();
      t_range();
      t_idle();
      t_sleep();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule